// File: doc/BRIEF.md
# Four-Class Egress Packet Scheduler

This block decides which of four class-of-service queues sends its next packet on one shared egress packet stream. Each class offers its head packet as a stream of data words. Packet length in words is given with the first word, and start and end markers frame the packet. The scheduler picks a class while the output is idle. It then connects that class straight through to the output until the last word of the packet has been accepted. Backpressure from the egress side is passed back to the class that is being served.

Two policies share the same four queues, and a small register port selects between them at run time. In strict mode the lowest-numbered class with a packet waiting always wins. In weighted mode the block runs deficit round robin over the classes. Each class has its own quantum, counted in words, which fixes its share of the link. A class that is the only one with traffic may use the whole link, whatever its quantum.

Top module: `egq_sched`

## Requirements
- R1: There are exactly four input classes and one output stream. While a packet is being sent, `out_data`, `out_sop` and `out_eop` equal the served class's inputs, and `out_cls` gives that class's number (0 to 3).
- R2: A class is chosen only while no packet is in flight. The output then stays on that class until a word with `out_eop` is accepted, so no word of another class appears inside a packet. A decision takes at least one cycle, during which `out_valid` is 0.
- R3: In strict mode, class 0 has the highest priority and class 3 the lowest. Each decision serves the lowest-numbered class whose `q_valid` is 1.
- R4: In weighted mode, a pointer visits the classes in the order 0,1,2,3,0 and starts at class 0 after reset. On arriving at a class with a packet waiting, the class's quantum is added to its deficit. The class then sends head packets while the head length is at most its deficit, and each packet sent subtracts its length. When the head does not fit, the pointer moves to the next class.
- R5: In weighted mode, a visited class with no packet waiting has its deficit cleared to zero, and the pointer moves on.
- R6: In weighted mode, when the visited class is the only class with `q_valid` set, its head packet is sent even if it does not fit. If it did not fit, the deficit becomes zero. A class with quantum 0 is therefore still served when it is alone.
- R7: Register writes use `cfg_we`, `cfg_addr` and `cfg_wdata`. Addresses 0 to 3 hold the quantum of classes 0 to 3. At address 4, bit 0 selects the mode (1 means strict, 0 means weighted). Addresses 5 to 7 are ignored. After reset the mode is weighted and every quantum is `RST_QUANTUM`.
- R8: A change of mode or quantum governs every decision made after the write takes effect, one cycle after the write cycle.
- R9: During and right after reset, `out_valid` is 0 and `q_ready` is all zeros.
- R10: `q_ready` has at most one bit set. The bit for the served class equals `out_ready` while a packet is in flight, so no word is lost or repeated under backpressure.
- R11: When no class has a packet waiting, the weighted-mode pointer and deficits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | QW | Register write data |
| q_valid | input | 4 | Per class: a word is offered |
| q_sop | input | 4 | Per class: offered word starts a packet |
| q_eop | input | 4 | Per class: offered word ends a packet |
| q_len | input | 4 x LW | Per class: head packet length in words, valid with the first word |
| q_data | input | 4 x DW | Per class: offered data word |
| q_ready | output | 4 | Per class: offered word is taken this cycle |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Egress accepts the word |
| out_sop | output | 1 | Output word starts a packet |
| out_eop | output | 1 | Output word ends a packet |
| out_cls | output | 2 | Class being served |
| out_data | output | DW | Output data word |

## Verification
The bench builds the block with 16-bit data, 8-bit length and quantum fields, and a reset quantum of 8. The wide data word lets each word carry its class, packet number and word number, so reordered, dropped or interleaved words show up directly. Random quanta from 0 to 15, against packet lengths from 1 to 8 words, reach packets that fit and packets that do not, carried-over deficits, zero quanta, and a lone class running beyond its quantum. The queue contents are fixed before each run. This makes the expected class order a pure function of the queues and the settings, whatever egress backpressure is applied.

// File: rtl/egq_pkg.sv
package egq_pkg;

    localparam int NCLS = 4;
    localparam int CW   = 2;

    typedef logic [CW-1:0] cls_t;

    typedef enum logic {
        SEL_DRR    = 1'b0,
        SEL_STRICT = 1'b1
    } sel_mode_e;

    localparam logic [2:0] ADDR_MODE = 3'd4;

    // Lowest-numbered class with a packet waiting.
    function automatic cls_t first_pending(input logic [NCLS-1:0] v);
        cls_t r;
        r = '0;
        for (int i = NCLS - 1; i >= 0; i--) begin
            if (v[i]) r = cls_t'(i);
        end
        return r;
    endfunction

    // Mask of every class with a higher priority than c.
    function automatic logic [NCLS-1:0] higher_mask(input cls_t c);
        logic [NCLS-1:0] m;
        for (int i = 0; i < NCLS; i++) m[i] = (i < int'(c));
        return m;
    endfunction

endpackage

// File: rtl/egq_cfg_regs.sv
module egq_cfg_regs
    import egq_pkg::*;
#(
    parameter int QW          = 8,
    parameter int RST_QUANTUM = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic [2:0]                 cfg_addr,
    input  logic [QW-1:0]              cfg_wdata,
    output logic [NCLS-1:0][QW-1:0]    quanta,
    output sel_mode_e                  mode
);

    for (genvar c = 0; c < NCLS; c++) begin : g_q
        always_ff @(posedge clk) begin
            if (rst)
                quanta[c] <= QW'(RST_QUANTUM);
            else if (cfg_we && cfg_addr == 3'(c))
                quanta[c] <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode <= SEL_DRR;
        else if (cfg_we && cfg_addr == ADDR_MODE)
            mode <= sel_mode_e'(cfg_wdata[0]);
    end

    // R7
    mode_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == ADDR_MODE) |=> (mode == sel_mode_e'($past(cfg_wdata[0]))));

endmodule

// File: rtl/egq_drr.sv
module egq_drr
    import egq_pkg::*;
#(
    parameter int LW = 8,
    parameter int QW = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [NCLS-1:0]          q_valid,
    input  logic [NCLS-1:0][LW-1:0]  q_len,
    input  logic [NCLS-1:0][QW-1:0]  quanta,
    output logic                     start,
    output cls_t                     pick
);

    localparam int DEF_W = ((QW > LW) ? QW : LW) + 2;

    cls_t                          rr;
    logic                          fresh;
    logic [NCLS-1:0][DEF_W-1:0]    def_q;

    logic [DEF_W-1:0] head_len;
    logic [DEF_W-1:0] cur_def;
    logic             fits;
    logic             sole;
    logic             any;

    always_comb begin
        head_len = {{(DEF_W-LW){1'b0}}, q_len[rr]};
        cur_def  = def_q[rr];
        fits     = head_len <= cur_def;
        any      = |q_valid;
        sole     = (q_valid == (NCLS'(1) << rr));
        start    = en && q_valid[rr] && !fresh && (fits || sole);
        pick     = rr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr    <= '0;
            fresh <= 1'b1;
            def_q <= '0;
        end else if (en && any) begin
            if (!q_valid[rr]) begin
                def_q[rr] <= '0;
                rr        <= rr + cls_t'(1);
                fresh     <= 1'b1;
            end else if (fresh) begin
                def_q[rr] <= cur_def + {{(DEF_W-QW){1'b0}}, quanta[rr]};
                fresh     <= 1'b0;
            end else if (fits) begin
                def_q[rr] <= cur_def - head_len;
            end else if (sole) begin
                def_q[rr] <= '0;
            end else begin
                rr    <= rr + cls_t'(1);
                fresh <= 1'b1;
            end
        end
    end

    // R5
    empty_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (en && any && !q_valid[rr]) |=> (def_q[$past(rr)] == '0));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !any) |=> ($stable(rr) && $stable(fresh) && $stable(def_q)));

endmodule

// File: rtl/egq_sched.sv
module egq_sched
    import egq_pkg::*;
#(
    parameter int DW          = 16,
    parameter int LW          = 8,
    parameter int QW          = 8,
    parameter int RST_QUANTUM = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_we,
    input  logic [2:0]               cfg_addr,
    input  logic [QW-1:0]            cfg_wdata,
    input  logic [NCLS-1:0]          q_valid,
    input  logic [NCLS-1:0]          q_sop,
    input  logic [NCLS-1:0]          q_eop,
    input  logic [NCLS-1:0][LW-1:0]  q_len,
    input  logic [NCLS-1:0][DW-1:0]  q_data,
    output logic [NCLS-1:0]          q_ready,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     out_sop,
    output logic                     out_eop,
    output logic [CW-1:0]            out_cls,
    output logic [DW-1:0]            out_data
);

    logic [NCLS-1:0][QW-1:0] quanta;
    sel_mode_e               mode;

    egq_cfg_regs #(.QW(QW), .RST_QUANTUM(RST_QUANTUM)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .quanta    (quanta),
        .mode      (mode)
    );

    logic busy;
    cls_t cur;
    logic drr_en, drr_start;
    cls_t drr_pick;
    logic strict_start;
    cls_t strict_pick;
    logic start;
    cls_t pick;
    logic fire;

    assign drr_en = !busy && (mode == SEL_DRR);

    egq_drr #(.LW(LW), .QW(QW)) u_drr (
        .clk     (clk),
        .rst     (rst),
        .en      (drr_en),
        .q_valid (q_valid),
        .q_len   (q_len),
        .quanta  (quanta),
        .start   (drr_start),
        .pick    (drr_pick)
    );

    always_comb begin
        strict_pick  = first_pending(q_valid);
        strict_start = !busy && (mode == SEL_STRICT) && (|q_valid);
        start        = drr_start || strict_start;
        pick         = (mode == SEL_STRICT) ? strict_pick : drr_pick;
    end

    always_comb begin
        out_valid = busy && q_valid[cur];
        out_sop   = out_valid && q_sop[cur];
        out_eop   = out_valid && q_eop[cur];
        out_data  = q_data[cur];
        out_cls   = cur;
        fire      = out_valid && out_ready;
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_rdy
        assign q_ready[c] = busy && (cur == cls_t'(c)) && out_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cur  <= pick;
            end
        end else if (fire && out_eop) begin
            busy <= 1'b0;
        end
    end

    // R10
    ready_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(q_ready));

    // R2
    no_interrupt_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !(fire && out_eop)) |=> (busy && $stable(cur)));

    // R3
    strict_order_chk: assert property (@(posedge clk) disable iff (rst)
        (strict_start) |-> ((q_valid & higher_mask(pick)) == '0 && q_valid[pick]));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && q_ready == '0));

endmodule

// File: tb/egq_sched_tb.sv
module egq_sched_tb;
    import egq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int LW = 8;
    localparam int QW = 8;
    localparam int RSTQ = 8;
    localparam int MAXP = 256;
    localparam int MAXE = 2048;
    localparam int PHASE_LIMIT = 6000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [QW-1:0] cfg_wdata = '0;
    logic [NCLS-1:0] q_valid, q_sop, q_eop;
    logic [NCLS-1:0][LW-1:0] q_len;
    logic [NCLS-1:0][DW-1:0] q_data;
    logic [NCLS-1:0] q_ready;
    logic out_valid, out_ready, out_sop, out_eop;
    logic [CW-1:0] out_cls;
    logic [DW-1:0] out_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    egq_sched #(.DW(DW), .LW(LW), .QW(QW), .RST_QUANTUM(RSTQ)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .q_valid(q_valid), .q_sop(q_sop), .q_eop(q_eop), .q_len(q_len), .q_data(q_data),
        .q_ready(q_ready), .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
        .out_eop(out_eop), .out_cls(out_cls), .out_data(out_data)
    );

    int errors = 0;
    int checks = 0;
    int plen [NCLS][MAXP];
    int head [NCLS];
    int tail [NCLS];
    int beat [NCLS];
    int mh   [NCLS];
    int m_def[NCLS];
    int m_q  [NCLS];
    int m_rr = 0;
    bit m_fresh = 1'b1;
    bit m_strict = 1'b0;
    int expc [MAXE];
    int exp_n = 0;
    int got_n = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive();
        for (int c = 0; c < NCLS; c++) begin
            if (head[c] < tail[c]) begin
                q_valid[c] = 1'b1;
                q_len[c]   = LW'(plen[c][head[c]]);
                q_sop[c]   = (beat[c] == 0);
                q_eop[c]   = (beat[c] == plen[c][head[c]] - 1);
                q_data[c]  = {2'(c), 8'(head[c]), 6'(beat[c])};
            end else begin
                q_valid[c] = 1'b0;
                q_len[c]   = '0;
                q_sop[c]   = 1'b0;
                q_eop[c]   = 1'b0;
                q_data[c]  = '0;
            end
        end
    endtask

    task automatic set_cfg(input int addr, input int val);
        cfg_we    = 1'b1;
        cfg_addr  = 3'(addr);
        cfg_wdata = QW'(val);
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (addr < NCLS) m_q[addr] = val;
        if (addr == 4) m_strict = val[0];
    endtask

    task automatic add_pkt(input int c, input int len);
        plen[c][tail[c]] = len;
        tail[c]++;
    endtask

    // Expected class order from R3..R6 and R11, queues fixed in advance.
    task automatic model_run();
        int guard;
        guard = 0;
        while (guard < 100000) begin
            int any, p, len;
            guard++;
            any = 0;
            for (int c = 0; c < NCLS; c++) if (mh[c] < tail[c]) any++;
            if (any == 0) break;
            if (m_strict) begin
                for (int c = NCLS - 1; c >= 0; c--) if (mh[c] < tail[c]) p = c;
                expc[exp_n] = p; exp_n++; mh[p]++;
            end else begin
                p = m_rr;
                if (mh[p] >= tail[p]) begin
                    m_def[p] = 0; m_rr = (p + 1) % NCLS; m_fresh = 1'b1;
                end else if (m_fresh) begin
                    m_def[p] += m_q[p]; m_fresh = 1'b0;
                end else begin
                    len = plen[p][mh[p]];
                    if (len <= m_def[p]) begin
                        m_def[p] -= len; expc[exp_n] = p; exp_n++; mh[p]++;
                    end else if (any == 1) begin
                        m_def[p] = 0; expc[exp_n] = p; exp_n++; mh[p]++;
                    end else begin
                        m_rr = (p + 1) % NCLS; m_fresh = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic run_phase(input string tag);
        bit done, fire;
        int wd, c, pk_cls, pk_err;
        logic [DW-1:0] expd;
        model_run();
        drive();
        done = 1'b1;
        for (int k = 0; k < NCLS; k++) if (head[k] < tail[k]) done = 1'b0;
        wd = 0; pk_cls = 0; pk_err = 0;
        while (!done) begin
            @(negedge clk);
            fire = out_valid && out_ready;
            if (out_valid && q_ready != (out_ready ? NCLS'(1) << out_cls : NCLS'(0)))
                pk_err++; // R10
            if (fire) begin
                c = int'(out_cls);
                if (out_sop) begin
                    check(got_n < exp_n && c == expc[got_n], tag, "class order",
                          c, (got_n < exp_n) ? expc[got_n] : -1);
                    got_n++;
                    pk_cls = c; pk_err = 0;
                end
                expd = {2'(c), 8'(head[c]), 6'(beat[c])};
                if (out_data != expd || c != pk_cls || out_sop != (beat[c] == 0) ||
                    out_eop != (beat[c] == plen[c][head[c]] - 1))
                    pk_err++;
                if (out_eop) check(pk_err == 0, "R1 R2 R10", "packet integrity", pk_err, 0);
            end
            @(posedge clk);
            #1;
            if (fire) begin
                c = int'(out_cls);
                beat[c]++;
                if (beat[c] == plen[c][head[c]]) begin beat[c] = 0; head[c]++; end
            end
            out_ready = ($urandom % 4) != 0;
            drive();
            done = 1'b1;
            for (int k = 0; k < NCLS; k++) if (head[k] < tail[k]) done = 1'b0;
            wd++;
            if (wd > PHASE_LIMIT) begin
                check(1'b0, "R2", "watchdog expired", wd, PHASE_LIMIT);
                break;
            end
        end
        out_ready = 1'b1;
        check(got_n == exp_n, tag, "packets delivered", got_n, exp_n);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int c = 0; c < NCLS; c++) begin
            head[c] = 0; tail[c] = 0; beat[c] = 0; mh[c] = 0; m_def[c] = 0; m_q[c] = RSTQ;
        end
        out_ready = 1'b1;
        drive();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R9
        check(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);
        check(q_ready == '0, "R9", "q_ready after reset", int'(q_ready), 0);
        @(posedge clk);
        #1;

        // R7 defaults: weighted mode, quantum RSTQ everywhere
        for (int c = 0; c < NCLS; c++)
            for (int k = 0; k < 4; k++) add_pkt(c, 1 + ($urandom % 8));
        run_phase("R7 R4");

        // R11: idle gap keeps weighted state; R8: switch to strict
        repeat (10) @(posedge clk);
        #1;
        set_cfg(4, 1);
        for (int c = NCLS - 1; c >= 0; c--)
            for (int k = 0; k < 3; k++) add_pkt(c, 1 + ($urandom % 8));
        run_phase("R3 R8");

        // R3: only classes 1 and 3 pending
        add_pkt(3, 2); add_pkt(1, 5); add_pkt(3, 1); add_pkt(1, 1);
        run_phase("R3");

        // R4 with unequal quanta, back to weighted
        set_cfg(4, 0);
        set_cfg(0, 12); set_cfg(1, 6); set_cfg(2, 3); set_cfg(3, 1);
        for (int c = 0; c < NCLS; c++)
            for (int k = 0; k < 5; k++) add_pkt(c, 1 + ($urandom % 8));
        run_phase("R4 R11");

        // R6: sole class with zero quantum
        set_cfg(2, 0);
        add_pkt(2, 7); add_pkt(2, 3); add_pkt(2, 8);
        run_phase("R6");

        // R7: writes to unused addresses are ignored
        set_cfg(6, 1); set_cfg(5, 0); set_cfg(7, 255);
        add_pkt(0, 4); add_pkt(1, 8); add_pkt(2, 2); add_pkt(3, 6); add_pkt(0, 8);
        run_phase("R7");

        // R5: long lengths with small quanta leave deficits, then a class empties
        set_cfg(0, 2); set_cfg(1, 9); set_cfg(2, 5); set_cfg(3, 4);
        add_pkt(0, 8); add_pkt(1, 1); add_pkt(1, 8); add_pkt(2, 3); add_pkt(3, 7); add_pkt(3, 2);
        run_phase("R5");

        for (int ph = 0; ph < 18; ph++) begin
            set_cfg(4, ($urandom % 3) == 0);
            for (int c = 0; c < NCLS; c++) set_cfg(c, $urandom % 16);
            for (int c = 0; c < NCLS; c++) begin
                int n;
                n = $urandom % 6;
                for (int k = 0; k < n; k++) add_pkt(c, 1 + ($urandom % 8));
            end
            run_phase(m_strict ? "R3 R8" : "R4 R5 R6");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule